// File: doc/BRIEF.md
# Conversion Cycle Controller with Abort

This block sequences a converter through its three phases: a conversion, a sleep with a result waiting, and a serial data transfer. It drives a busy status line that is high only while a conversion runs. It issues a one-cycle start pulse each time a conversion begins. It also raises a data-phase enable that lets the serial shift logic run. The converter core is not part of the block. An internal countdown timer, loaded from a programmable length, stands in for the conversion time.

The host starts a transfer by pulling the active-low chip select low while the block sleeps. A transfer ends in one of two ways. In the normal case, the word finishes once the configured number of serial clock edges has been seen. In the early case, chip select returns high, which abandons the rest of the word. Either way a new conversion starts at once. Chip select comes from outside the clock domain, so it passes through a two-stage synchroniser before the block looks for its edges. Serial clock edges arrive as single-cycle strobes that are already in the block's clock domain. After reset, one conversion runs on its own before the first transfer can begin.

Top module: `conv_seq_ctrl`

## Requirements
- R1: While reset is applied, busy is 1 and data_en and start_conv are 0. In the first cycle after the first clock edge that follows reset release, start_conv is 1 and busy is 1, so a conversion starts automatically.
- R2: Each conversion holds busy high for exactly conv_len cycles, counting from the cycle in which start_conv is 1. A conv_len of 0 behaves as 1.
- R3: When a conversion ends, busy goes low and the block sleeps with data_en at 0. It stays asleep while cs_n is held high.
- R4: While the block sleeps, a low level on cs_n makes data_en go high 3 clock edges after cs_n is sampled low (2 edges of synchroniser plus one of state). Busy stays 0 during both sleep and transfer.
- R5: During the data phase, the sck_edge strobe that completes the word ends the phase at the next edge: data_en goes to 0, and start_conv and busy go to 1. The word length is word_len, where 0 counts as 1 and values above MAX_BITS count as MAX_BITS.
- R6: A rising edge on cs_n during the data phase aborts the transfer, whatever number of bits has been counted. Three edges after cs_n is sampled high, data_en is 0 and start_conv and busy are 1.
- R7: A rising edge on cs_n during a conversion is ignored, and the conversion length is unchanged.
- R8: sck_edge strobes outside the data phase are not counted. Every data phase begins counting from zero.
- R9: start_conv is a single-cycle pulse, and it is high only while busy is high.
- R10: busy and data_en are never both high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Block clock |
| rst_n | input | 1 | Active-low synchronous reset |
| cs_n | input | 1 | Active-low chip select, asynchronous to clk |
| sck_edge | input | 1 | Single-cycle strobe, one per serial clock edge of the transfer |
| conv_len | input | CNT_W (16) | Conversion length in clock cycles, taken when a conversion starts |
| word_len | input | BIT_W (6) | Number of bits in one output word |
| busy | output | 1 | High while a conversion is in progress |
| start_conv | output | 1 | One-cycle pulse in the first cycle of each conversion |
| data_en | output | 1 | High during the data-output phase, and enables the shift logic |

## Verification
The bench builds the block with its default parameters: a 16-bit conversion length, a maximum word of 32 bits and a two-stage synchroniser. Because conv_len and word_len are ports, each test vector picks short conversions of 0 to 20 cycles and words from 1 bit to beyond the 32-bit cap. This brings every phase transition within reach in a few hundred cycles. The same vectors cover aborts at bit 0, in the middle of a word and one bit before the end. They also cover chip-select activity during a conversion and serial strobes seen during sleep.

// File: rtl/conv_seq_pkg.sv
package conv_seq_pkg;

  typedef enum logic [1:0] {
    ST_BOOT  = 2'd0,
    ST_CONV  = 2'd1,
    ST_SLEEP = 2'd2,
    ST_XFER  = 2'd3
  } phase_t;

  // busy is reported in the start-up phase and during a conversion
  function automatic logic phase_busy(input phase_t p);
    return (p == ST_BOOT) || (p == ST_CONV);
  endfunction

  function automatic logic phase_xfer(input phase_t p);
    return (p == ST_XFER);
  endfunction

endpackage

// File: rtl/cs_sync.sv
module cs_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  input  logic cs_n,
  output logic cs_lvl,
  output logic cs_rise
);
  localparam int TOP = STAGES - 1;

  logic [TOP:0] chain;
  logic         lvl_q;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      chain <= '1;
      lvl_q <= 1'b1;
    end else begin
      chain <= {chain[TOP-1:0], cs_n};
      lvl_q <= chain[TOP];
    end
  end

  assign cs_lvl  = chain[TOP];
  assign cs_rise = chain[TOP] & ~lvl_q;
endmodule

// File: rtl/conv_timer.sv
module conv_timer #(
  parameter int CNT_W = 16
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             load,
  input  logic             run,
  input  logic [CNT_W-1:0] len,
  output logic             done
);
  localparam logic [CNT_W-1:0] ONE = CNT_W'(1);

  function automatic logic [CNT_W-1:0] clamp_len(input logic [CNT_W-1:0] l);
    return (l == '0) ? ONE : l;
  endfunction

  logic [CNT_W-1:0] remain;

  always_ff @(posedge clk) begin
    if (!rst_n)                   remain <= '0;
    else if (load)                remain <= clamp_len(len);
    else if (run && remain > ONE) remain <= remain - ONE;
  end

  assign done = run && (remain == ONE);
endmodule

// File: rtl/bit_counter.sv
module bit_counter #(
  parameter int MAX_BITS = 32,
  parameter int BIT_W    = $clog2(MAX_BITS + 1)
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             clr,
  input  logic             inc,
  input  logic [BIT_W-1:0] word_len,
  output logic             last
);
  localparam logic [BIT_W-1:0] MAXV = BIT_W'(MAX_BITS);
  localparam logic [BIT_W-1:0] ONE  = BIT_W'(1);

  function automatic logic [BIT_W-1:0] clamp_word(input logic [BIT_W-1:0] w);
    if (w == '0)  return ONE;
    if (w > MAXV) return MAXV;
    return w;
  endfunction

  logic [BIT_W-1:0] seen;

  always_ff @(posedge clk) begin
    if (!rst_n)   seen <= '0;
    else if (clr) seen <= '0;
    else if (inc) seen <= seen + ONE;
  end

  assign last = inc && (seen == clamp_word(word_len) - ONE);
endmodule

// File: rtl/conv_seq_ctrl.sv
module conv_seq_ctrl #(
  parameter int CNT_W       = 16,
  parameter int MAX_BITS    = 32,
  parameter int SYNC_STAGES = 2,
  localparam int BIT_W      = $clog2(MAX_BITS + 1)
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             cs_n,
  input  logic             sck_edge,
  input  logic [CNT_W-1:0] conv_len,
  input  logic [BIT_W-1:0] word_len,
  output logic             busy,
  output logic             start_conv,
  output logic             data_en
);
  import conv_seq_pkg::*;

  phase_t phase, phase_nxt;
  logic   launch;
  logic   start_q;
  logic   cs_lvl, cs_rise;
  logic   conv_done;
  logic   word_last;
  logic   in_xfer;

  cs_sync #(.STAGES(SYNC_STAGES)) u_sync (
    .clk(clk), .rst_n(rst_n), .cs_n(cs_n),
    .cs_lvl(cs_lvl), .cs_rise(cs_rise)
  );

  conv_timer #(.CNT_W(CNT_W)) u_timer (
    .clk(clk), .rst_n(rst_n), .load(launch),
    .run(phase == ST_CONV), .len(conv_len), .done(conv_done)
  );

  bit_counter #(.MAX_BITS(MAX_BITS), .BIT_W(BIT_W)) u_bits (
    .clk(clk), .rst_n(rst_n), .clr(!in_xfer),
    .inc(in_xfer && sck_edge), .word_len(word_len), .last(word_last)
  );

  assign in_xfer = phase_xfer(phase);

  always_comb begin
    phase_nxt = phase;
    launch    = 1'b0;
    unique case (phase)
      ST_BOOT: begin
        launch    = 1'b1;
        phase_nxt = ST_CONV;
      end
      ST_CONV:  if (conv_done) phase_nxt = ST_SLEEP;
      ST_SLEEP: if (!cs_lvl)   phase_nxt = ST_XFER;
      ST_XFER: begin
        if (cs_rise || word_last) begin
          launch    = 1'b1;
          phase_nxt = ST_CONV;
        end
      end
      default: phase_nxt = ST_BOOT;
    endcase
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      phase   <= ST_BOOT;
      start_q <= 1'b0;
    end else begin
      phase   <= phase_nxt;
      start_q <= launch;
    end
  end

  assign busy       = phase_busy(phase);
  assign data_en    = in_xfer;
  assign start_conv = start_q;
endmodule

// File: rtl/conv_seq_ctrl_chk.sv
module conv_seq_ctrl_chk (
  input logic clk,
  input logic rst_n,
  input logic busy,
  input logic data_en,
  input logic start_conv,
  input logic cs_lvl,
  input logic cs_rise,
  input logic conv_done,
  input logic word_last
);
  assert_excl_R10: assert property (@(posedge clk) disable iff (!rst_n)
    !(busy && data_en));

  assert_start_busy_R9: assert property (@(posedge clk) disable iff (!rst_n)
    start_conv |-> busy);

  assert_start_single_R9: assert property (@(posedge clk) disable iff (!rst_n)
    start_conv |=> !start_conv);

  assert_conv_hold_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (busy && !conv_done) |=> busy);

  assert_conv_end_R3: assert property (@(posedge clk) disable iff (!rst_n)
    conv_done |=> (!busy && !data_en));

  assert_sleep_exit_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (!busy && !data_en && !cs_lvl) |=> data_en);

  assert_word_end_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (data_en && word_last) |=> (start_conv && busy));

  assert_abort_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (data_en && cs_rise) |=> (start_conv && !data_en));
endmodule

bind conv_seq_ctrl conv_seq_ctrl_chk u_chk (
  .clk(clk), .rst_n(rst_n), .busy(busy), .data_en(data_en),
  .start_conv(start_conv), .cs_lvl(cs_lvl), .cs_rise(cs_rise),
  .conv_done(conv_done), .word_last(word_last)
);

// File: tb/conv_seq_ctrl_bench.sv
module conv_seq_ctrl_bench;
  localparam int CNT_W    = 16;
  localparam int MAX_BITS = 32;
  localparam int BIT_W    = 6;
  localparam logic [7:0] NO_ABORT = 8'hFF;

  // {conv_len[31:16], word_len[15:8], abort_after_bits[7:0]}
  localparam logic [31:0] VEC [8] = '{
    {16'd5,  8'd4,  NO_ABORT},
    {16'd12, 8'd8,  8'd3},
    {16'd1,  8'd1,  NO_ABORT},
    {16'd20, 8'd16, NO_ABORT},
    {16'd9,  8'd6,  8'd0},
    {16'd0,  8'd3,  NO_ABORT},
    {16'd3,  8'd32, 8'd31},
    {16'd10, 8'd40, NO_ABORT}
  };

  logic             clk = 1'b0;
  logic             rst_n = 1'b0;
  logic             cs_n = 1'b1;
  logic             sck_edge = 1'b0;
  logic [CNT_W-1:0] conv_len = 16'd6;
  logic [BIT_W-1:0] word_len = 6'd8;
  logic             busy, start_conv, data_en;

  int checks = 0;
  int fails  = 0;
  bit finished = 1'b0;

  always #5 clk = ~clk;

  conv_seq_ctrl u_conv_seq_ctrl (
    .clk(clk), .rst_n(rst_n), .cs_n(cs_n), .sck_edge(sck_edge),
    .conv_len(conv_len), .word_len(word_len),
    .busy(busy), .start_conv(start_conv), .data_en(data_en)
  );

  function automatic int exp_len(input int l);
    return (l == 0) ? 1 : l;
  endfunction

  function automatic int exp_word(input int w);
    if (w == 0) return 1;
    return (w > MAX_BITS) ? MAX_BITS : w;
  endfunction

  task automatic check(input bit ok, input string req, input string what,
                       input int act, input int exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s %s: actual %0d expected %0d", req, what, act, exp);
    end
  endtask

  task automatic report;
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  endtask

  // called at the sample where start_conv is high; returns busy-high cycles
  task automatic measure_conv(input bit wiggle, output int n);
    n = 0;
    while (busy) begin
      if (wiggle && n == 1) cs_n = 1'b0;
      if (wiggle && n == 3) cs_n = 1'b1;
      n++;
      @(negedge clk);
      if (n > 70000) break;
    end
  endtask

  initial begin
    int n;
    @(negedge clk); @(negedge clk);
    // R1: values held during reset
    check(busy == 1'b1, "R1", "busy in reset", busy, 1);
    check(data_en == 1'b0 && start_conv == 1'b0, "R1", "data_en|start in reset",
          data_en | start_conv, 0);
    rst_n = 1'b1;
    @(negedge clk);
    check(start_conv == 1'b1 && busy == 1'b1, "R1", "start after release",
          start_conv, 1);
    measure_conv(1'b0, n);
    check(n == 6, "R2", "boot conversion length", n, 6);

    foreach (VEC[vi]) begin
      int clen, wlen, ab, nb, held;
      clen = int'(VEC[vi][31:16]);
      wlen = int'(VEC[vi][15:8]);
      ab   = int'(VEC[vi][7:0]);
      conv_len = CNT_W'(clen);
      word_len = BIT_W'(wlen);
      // R3: asleep while cs_n high
      repeat (3) @(negedge clk);
      check(busy == 1'b0 && data_en == 1'b0, "R3", "sleep after conversion",
            busy | data_en, 0);
      // R8: strobes during sleep are not counted
      repeat (2) begin
        sck_edge = 1'b1; @(negedge clk);
        sck_edge = 1'b0; @(negedge clk);
      end
      check(data_en == 1'b0, "R8", "sleep strobes ignored", data_en, 0);
      cs_n = 1'b0;
      @(negedge clk); @(negedge clk);
      check(data_en == 1'b0, "R4", "data_en before sync latency", data_en, 0);
      @(negedge clk);
      check(data_en == 1'b1 && busy == 1'b0, "R4", "data phase entered",
            data_en, 1);
      nb = (ab == int'(NO_ABORT)) ? exp_word(wlen) : ab;
      held = 1;
      for (int i = 0; i < nb; i++) begin
        sck_edge = 1'b1;
        if (ab == int'(NO_ABORT) && i == nb - 1) cs_n = 1'b1;
        @(negedge clk);
        sck_edge = 1'b0;
        if (i < nb - 1 || ab != int'(NO_ABORT))
          if (!(data_en && !busy)) held = 0;
      end
      check(held == 1, "R8", "data phase held before word end", held, 1);
      if (ab == int'(NO_ABORT)) begin
        check(start_conv && busy && !data_en, "R5", "word completion starts conversion",
              {start_conv, busy, data_en}, 3'b110);
      end else begin
        cs_n = 1'b1;
        @(negedge clk);
        @(negedge clk);
        check(data_en == 1'b1, "R6", "abort not before sync latency", data_en, 1);
        @(negedge clk);
        check(start_conv && busy && !data_en, "R6", "abort starts conversion",
              {start_conv, busy, data_en}, 3'b110);
      end
      measure_conv(clen >= 8, n);
      check(n == exp_len(clen), (clen >= 8) ? "R7" : "R2", "conversion length",
            n, exp_len(clen));
    end

    // reset during a transfer returns to the reset values and reboots
    cs_n = 1'b0;
    repeat (3) @(negedge clk);
    check(data_en == 1'b1, "R4", "data phase before reset", data_en, 1);
    rst_n = 1'b0; cs_n = 1'b1;
    @(negedge clk);
    check(busy == 1'b1 && data_en == 1'b0, "R1", "reset mid-transfer",
          {busy, data_en}, 2'b10);
    conv_len = 16'd2;
    rst_n = 1'b1;
    @(negedge clk);
    check(start_conv == 1'b1, "R1", "reboot conversion", start_conv, 1);
    measure_conv(1'b0, n);
    check(n == 2, "R2", "reboot conversion length", n, 2);
    @(negedge clk);
    check(start_conv == 1'b0 && busy == 1'b0, "R9", "no stray start",
          start_conv, 0);

    finished = 1'b1;
    report();
  end

  initial begin
    repeat (200000) @(posedge clk);
    if (!finished) begin
      checks++;
      fails++;
      $display("FAIL watchdog: actual timeout expected completion");
      report();
    end
  end
endmodule